// File: doc/BRIEF.md
# ATA Task File Register Bank

This block holds the legacy disk command-block and control registers that a host reaches through a plain byte-wide register port. The host uses this port to load a feature byte, a sector count, a three-byte block address and a drive/head byte. It then writes a command code and polls or waits on status. A device core beside the block takes each accepted command as a one-cycle strobe, together with the full 16-bit and 48-bit parameter values. The core sends back status, error and completion-count updates through a small set of input strobes.

Every parameter register keeps the value it held before its latest write. Two writes in a row therefore give a 16-bit or 48-bit operand. The high-order-byte select bit in device control makes host reads return those older values. The block also handles the following:
- an interrupt request, gated by an active-low enable and acknowledged by a status read;
- a soft-reset level that holds the bank cleared while it is set;
- a read-only drive address byte built from inverted head bits and a write-in-progress flag.

Top module: `tskf_regbank`

## Requirements
- R1: After reset, status reads 0x80 (busy set, ready clear), error reads 0x00, drive/head reads 0xA0, device control is 0, intrq and soft_rst are low and every parameter output is 0.
- R2: A host write to address 0 (feature), 1 (sector count), 2/3/4 (LBA low/mid/high) or 5 (drive/head) moves that register's current byte into its previous byte and loads the new byte. feature_out and count_out are {previous, current}. lba_out is {prev high, prev mid, prev low, cur high, cur mid, cur low}.
- R3: With device control bit 7 (HOB) set, reads of addresses 1 to 5 return the previous bytes. Without it they return the current bytes. Any host write to addresses 0 to 6 clears HOB.
- R4: Drive/head reads always show bit 7 = 1, bit 5 = 1 and bit 4 = 0. Bit 6 of the current byte drives lba_mode and bits 3:0 drive head_out.
- R5: A read of address 0 returns the error byte, where bit 7 = bad block, bit 6 = uncorrectable, bit 4 = ID not found, bit 2 = abort and bit 0 = general error. Bits 5, 3 and 1 always read 0. Status bit 1 always reads 0.
- R6: A host write to address 6 is accepted only while status bit 7 (busy) is 0 and soft reset is off. An accepted write gives a one-cycle cmd_valid with cmd_code in the next cycle, sets busy, clears status bit 0 and clears the error byte. A write that is not accepted changes nothing.
- R7: core_upd loads status (bit 7 busy, 6 ready, 5 write fault, 4 seek complete, 3 data request, 2 corrected, 0 error) and the error byte. Until the first update, ready reads 0. An accepted command write in the same cycle takes priority.
- R8: core_irq sets a pending flag, and intrq = pending AND NOT device-control bit 1. A status read at address 6 clears pending. A read at address 7 returns the same status without clearing it. A set and a clear in the same cycle leave pending set.
- R9: While device-control bit 2 is 1, soft_rst is high and the following hold: all parameter bytes read 0, status reads 0x80, error reads 0, pending is clear, and host parameter and command writes are ignored. The state holds until bit 2 is written back to 0.
- R10: Address 8 reads the drive address byte: bit 7 = 0, bit 6 = NOT core_wr_active, bits 5:2 = inverted current head bits, bits 1:0 = 2'b10 (drive 0 selected, active low).
- R11: core_cnt_we loads the current sector count without touching the previous byte. A host write in the same cycle wins. xfer_sectors shows 256 when the current count is 0, and the count itself otherwise.
- R12: Reads of addresses 9 to 15 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs | input | 1 | Host access this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational) |
| core_upd | input | 1 | Load status and error from core |
| core_status | input | 8 | Status byte from core |
| core_error | input | 8 | Error byte from core |
| core_irq | input | 1 | Raise interrupt pending |
| core_wr_active | input | 1 | Core is writing media |
| core_cnt_we | input | 1 | Load remaining sector count |
| core_cnt | input | 8 | Remaining sector count |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | 8 | Accepted command code |
| feature_out | output | 16 | {previous, current} feature |
| count_out | output | 16 | {previous, current} sector count |
| lba_out | output | 48 | 48-bit block address |
| head_out | output | 4 | Head / LBA bits 27:24 |
| lba_mode | output | 1 | Block addressing selected |
| xfer_sectors | output | 9 | Current count with 0 read as 256 |
| intrq | output | 1 | Interrupt request |
| soft_rst | output | 1 | Soft reset held |

## Verification
The bench targets the following corner cases:
- **Status read and core interrupt in the same cycle.** A design that let the clear win would lose an interrupt.
- **Auxiliary status read.** A design that also acknowledged here would drop intrq early.
- **Command write while busy.** A design without the lock would issue a second strobe.
- **Core count load and host count write in the same cycle.** The wrong priority, or a load that shifted the previous byte, shows up on count_out.

The bench also sets HOB and then writes to a parameter register, to check that HOB clears. It reads drive/head after writing zero and all-ones to it, to expose the forced bits. It holds soft reset over several cycles of host writes, to show that nothing leaks through before release.

// File: rtl/tskf_pkg.sv
package tskf_pkg;

   localparam int TSKF_BYTE_W   = 8;
   localparam int TSKF_NUM_PAR  = 6;

   localparam logic [3:0] A_FEAT   = 4'd0;
   localparam logic [3:0] A_COUNT  = 4'd1;
   localparam logic [3:0] A_LBA_LO = 4'd2;
   localparam logic [3:0] A_LBA_MD = 4'd3;
   localparam logic [3:0] A_LBA_HI = 4'd4;
   localparam logic [3:0] A_DEVHD  = 4'd5;
   localparam logic [3:0] A_CMD    = 4'd6;
   localparam logic [3:0] A_CTRL   = 4'd7;
   localparam logic [3:0] A_DRVADR = 4'd8;

   localparam int ST_BUSY = 7;
   localparam int ST_ERR  = 0;
   localparam int ST_IDX  = 1;

   localparam int CT_HOB  = 7;
   localparam int CT_SRST = 2;
   localparam int CT_NIEN = 1;

   localparam logic [7:0] ERR_KEEP_MASK = 8'hD5;
   localparam logic [7:0] STAT_KEEP_MASK = ~(8'h01 << ST_IDX);
   localparam logic [7:0] DEVHD_SET    = 8'hA0;
   localparam logic [7:0] DEVHD_CLR    = 8'h10;
   localparam logic [7:0] STAT_RESET   = 8'h80;

   typedef struct packed {
      logic hob;
      logic srst;
      logic nien;
   } devctl_t;

endpackage

// File: rtl/tskf_byte_pair.sv
module tskf_byte_pair #(
   parameter int W         = 8,
   parameter bit KEEP_PREV = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         ld_en,
   input  logic [W-1:0] ld_data,
   output logic [W-1:0] cur_q,
   output logic [W-1:0] prev_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '0;
      end else if (clr) begin
         cur_q <= '0;
      end else if (wr_en) begin
         cur_q <= wr_data;
      end else if (ld_en) begin
         cur_q <= ld_data;
      end
   end

   generate
      if (KEEP_PREV) begin : g_prev
         logic [W-1:0] prev_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_r <= '0;
            end else if (clr) begin
               prev_r <= '0;
            end else if (wr_en) begin
               prev_r <= cur_q;
            end
         end
         assign prev_q = prev_r;
      end else begin : g_noprev
         assign prev_q = '0;
      end
   endgenerate

endmodule

// File: rtl/tskf_status_unit.sv
module tskf_status_unit
   import tskf_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         cmd_acc,
   input  logic         core_upd,
   input  logic [W-1:0] core_status,
   input  logic [W-1:0] core_error,
   input  logic         core_irq,
   input  logic         stat_rd,
   output logic [W-1:0] stat_q,
   output logic [W-1:0] err_q,
   output logic         pend_q
);

   localparam logic [W-1:0] BUSY_BIT = W'(1) << ST_BUSY;
   localparam logic [W-1:0] ERR_BIT  = W'(1) << ST_ERR;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= W'(STAT_RESET);
         err_q  <= '0;
      end else if (clr) begin
         stat_q <= W'(STAT_RESET);
         err_q  <= '0;
      end else if (cmd_acc) begin
         stat_q <= (stat_q | BUSY_BIT) & ~ERR_BIT;
         err_q  <= '0;
      end else if (core_upd) begin
         stat_q <= core_status & W'(STAT_KEEP_MASK);
         err_q  <= core_error & W'(ERR_KEEP_MASK);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (clr) begin
         pend_q <= 1'b0;
      end else if (core_irq) begin
         pend_q <= 1'b1;
      end else if (stat_rd) begin
         pend_q <= 1'b0;
      end
   end

endmodule

// File: rtl/tskf_devctl.sv
module tskf_devctl
   import tskf_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_ctl,
   input  logic         wr_cmdblk,
   input  logic [W-1:0] wdata,
   output devctl_t      ctl_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr_ctl) begin
         ctl_q.hob  <= wdata[CT_HOB];
         ctl_q.srst <= wdata[CT_SRST];
         ctl_q.nien <= wdata[CT_NIEN];
      end else if (wr_cmdblk) begin
         ctl_q.hob  <= 1'b0;
      end
   end

endmodule

// File: rtl/tskf_regbank.sv
module tskf_regbank
   import tskf_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 4,
   parameter bit HOB_SHADOW = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  host_cs,
   input  logic                  host_we,
   input  logic [ADDR_W-1:0]     host_addr,
   input  logic [DATA_W-1:0]     host_wdata,
   output logic [DATA_W-1:0]     host_rdata,
   input  logic                  core_upd,
   input  logic [DATA_W-1:0]     core_status,
   input  logic [DATA_W-1:0]     core_error,
   input  logic                  core_irq,
   input  logic                  core_wr_active,
   input  logic                  core_cnt_we,
   input  logic [DATA_W-1:0]     core_cnt,
   output logic                  cmd_valid,
   output logic [DATA_W-1:0]     cmd_code,
   output logic [2*DATA_W-1:0]   feature_out,
   output logic [2*DATA_W-1:0]   count_out,
   output logic [6*DATA_W-1:0]   lba_out,
   output logic [3:0]            head_out,
   output logic                  lba_mode,
   output logic [DATA_W:0]       xfer_sectors,
   output logic                  intrq,
   output logic                  soft_rst
);

   localparam int NPAR = TSKF_NUM_PAR;
   localparam int I_FEAT  = int'(A_FEAT);
   localparam int I_COUNT = int'(A_COUNT);
   localparam int I_LO    = int'(A_LBA_LO);
   localparam int I_MD    = int'(A_LBA_MD);
   localparam int I_HI    = int'(A_LBA_HI);
   localparam int I_DH    = int'(A_DEVHD);
   localparam logic [DATA_W:0] FULL_COUNT = (DATA_W+1)'(1) << DATA_W;

   generate
      if (DATA_W != TSKF_BYTE_W) begin : g_bad_width
         $error("tskf_regbank: DATA_W must equal the register byte width");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("tskf_regbank: ADDR_W must cover nine registers");
      end
   endgenerate

   logic [DATA_W-1:0] cur_b  [NPAR];
   logic [DATA_W-1:0] prev_b [NPAR];
   logic [DATA_W-1:0] stat_q;
   logic [DATA_W-1:0] err_q;
   logic              pend_q;
   devctl_t           ctl_q;
   logic              hob_q;
   logic              nien_q;
   logic              srst_q;

   logic host_wr;
   logic host_rd;
   logic wr_cmdblk;
   logic cmd_acc;
   logic stat_rd;

   assign host_wr   = host_cs & host_we;
   assign host_rd   = host_cs & ~host_we;
   assign wr_cmdblk = host_wr & (host_addr <= ADDR_W'(A_CMD));
   assign hob_q     = ctl_q.hob;
   assign nien_q    = ctl_q.nien;
   assign srst_q    = ctl_q.srst;
   assign cmd_acc   = host_wr & (host_addr == ADDR_W'(A_CMD))
                      & ~stat_q[ST_BUSY] & ~srst_q;
   assign stat_rd   = host_rd & (host_addr == ADDR_W'(A_CMD));

   genvar gi;
   generate
      for (gi = 0; gi < NPAR; gi++) begin : g_par
         logic ld_en_w;
         if (gi == I_COUNT) begin : g_ld
            assign ld_en_w = core_cnt_we;
         end else begin : g_nold
            assign ld_en_w = 1'b0;
         end
         tskf_byte_pair #(
            .W         (DATA_W),
            .KEEP_PREV (HOB_SHADOW)
         ) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (srst_q),
            .wr_en   (host_wr & (host_addr == ADDR_W'(gi))),
            .wr_data (host_wdata),
            .ld_en   (ld_en_w),
            .ld_data (core_cnt),
            .cur_q   (cur_b[gi]),
            .prev_q  (prev_b[gi])
         );
      end
   endgenerate

   tskf_status_unit #(.W(DATA_W)) u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (srst_q),
      .cmd_acc     (cmd_acc),
      .core_upd    (core_upd),
      .core_status (core_status),
      .core_error  (core_error),
      .core_irq    (core_irq),
      .stat_rd     (stat_rd),
      .stat_q      (stat_q),
      .err_q       (err_q),
      .pend_q      (pend_q)
   );

   tskf_devctl #(.W(DATA_W)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctl    (host_wr & (host_addr == ADDR_W'(A_CTRL))),
      .wr_cmdblk (wr_cmdblk),
      .wdata     (host_wdata),
      .ctl_q     (ctl_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_code  <= '0;
      end else begin
         cmd_valid <= cmd_acc;
         if (cmd_acc) begin
            cmd_code <= host_wdata;
         end
      end
   end

   function automatic logic [DATA_W-1:0] fix_devhd(input logic [DATA_W-1:0] v);
      return (v | DATA_W'(DEVHD_SET)) & ~DATA_W'(DEVHD_CLR);
   endfunction

   logic [DATA_W-1:0] drv_addr;
   assign drv_addr = {1'b0, ~core_wr_active, ~cur_b[I_DH][3:0], 2'b10};

   always_comb begin
      host_rdata = '0;
      if (host_addr == ADDR_W'(A_FEAT)) begin
         host_rdata = err_q;
      end else if (host_addr >= ADDR_W'(A_COUNT) && host_addr <= ADDR_W'(A_DEVHD)) begin
         for (int k = I_COUNT; k <= I_DH; k++) begin
            if (host_addr == ADDR_W'(k)) begin
               host_rdata = hob_q ? prev_b[k] : cur_b[k];
            end
         end
         if (host_addr == ADDR_W'(A_DEVHD)) begin
            host_rdata = fix_devhd(host_rdata);
         end
      end else if (host_addr == ADDR_W'(A_CMD) || host_addr == ADDR_W'(A_CTRL)) begin
         host_rdata = stat_q;
      end else if (host_addr == ADDR_W'(A_DRVADR)) begin
         host_rdata = drv_addr;
      end
   end

   assign feature_out  = {prev_b[I_FEAT], cur_b[I_FEAT]};
   assign count_out    = {prev_b[I_COUNT], cur_b[I_COUNT]};
   assign lba_out      = {prev_b[I_HI], prev_b[I_MD], prev_b[I_LO],
                          cur_b[I_HI],  cur_b[I_MD],  cur_b[I_LO]};
   assign head_out     = cur_b[I_DH][3:0];
   assign lba_mode     = cur_b[I_DH][6];
   assign xfer_sectors = (cur_b[I_COUNT] == '0) ? FULL_COUNT
                                                : {1'b0, cur_b[I_COUNT]};
   assign intrq        = pend_q & ~nien_q;
   assign soft_rst     = srst_q;

endmodule

// File: rtl/tskf_regbank_chk.sv
module tskf_regbank_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_cs,
   input logic              host_we,
   input logic [ADDR_W-1:0] host_addr,
   input logic              core_irq,
   input logic              cmd_valid,
   input logic              intrq,
   input logic              soft_rst,
   input logic [DATA_W-1:0] stat_q,
   input logic              nien_q,
   input logic              hob_q
);

   p_cmd_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   p_busy_after_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !soft_rst) |-> stat_q[7]);

   p_cmd_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_cs && host_we && host_addr == ADDR_W'(6) && stat_q[7]) |=> !cmd_valid);

   p_hob_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_cs && host_we && host_addr <= ADDR_W'(6)) |=> !hob_q);

   p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      nien_q |-> !intrq);

   p_stat_read_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_cs && !host_we && host_addr == ADDR_W'(6) && !core_irq) |=> !intrq);

   p_srst_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && $past(soft_rst)) |-> (!intrq && !cmd_valid));

endmodule

bind tskf_regbank tskf_regbank_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_cs   (host_cs),
   .host_we   (host_we),
   .host_addr (host_addr),
   .core_irq  (core_irq),
   .cmd_valid (cmd_valid),
   .intrq     (intrq),
   .soft_rst  (soft_rst),
   .stat_q    (stat_q),
   .nien_q    (nien_q),
   .hob_q     (hob_q)
);

// File: tb/sim_tskf_regbank.sv
`timescale 1ns/1ps
module sim_tskf_regbank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_cs = 1'b0, host_we = 1'b0;
   logic [3:0]  host_addr = '0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        core_upd = 1'b0, core_irq = 1'b0, core_wr_active = 1'b0, core_cnt_we = 1'b0;
   logic [7:0]  core_status = '0, core_error = '0, core_cnt = '0;
   logic        cmd_valid, lba_mode, intrq, soft_rst;
   logic [7:0]  cmd_code;
   logic [15:0] feature_out, count_out;
   logic [47:0] lba_out;
   logic [3:0]  head_out;
   logic [8:0]  xfer_sectors;

   always #5 clk = ~clk;

   tskf_regbank u0 (
      .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .core_upd(core_upd), .core_status(core_status), .core_error(core_error),
      .core_irq(core_irq), .core_wr_active(core_wr_active),
      .core_cnt_we(core_cnt_we), .core_cnt(core_cnt),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .feature_out(feature_out),
      .count_out(count_out), .lba_out(lba_out), .head_out(head_out),
      .lba_mode(lba_mode), .xfer_sectors(xfer_sectors), .intrq(intrq),
      .soft_rst(soft_rst)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit chk_on = 1'b0;
   bit done = 1'b0;

   logic [7:0] m_cur [6];
   logic [7:0] m_prev[6];
   logic [7:0] m_stat, m_err, m_cmdc;
   bit m_pend, m_hob, m_srst, m_nien, m_cmdv;

   task automatic model_reset();
      for (int i = 0; i < 6; i++) begin m_cur[i] = 8'h00; m_prev[i] = 8'h00; end
      m_stat = 8'h80; m_err = 8'h00; m_cmdc = 8'h00;
      m_pend = 0; m_hob = 0; m_srst = 0; m_nien = 0; m_cmdv = 0;
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         bit wr, rd, acc, clr;
         int a;
         wr  = host_cs && host_we;
         rd  = host_cs && !host_we;
         a   = int'(host_addr);
         clr = m_srst;
         acc = wr && a == 6 && !m_stat[7] && !m_srst;
         if (clr) begin
            for (int i = 0; i < 6; i++) begin m_cur[i] = 8'h00; m_prev[i] = 8'h00; end
         end else if (wr && a <= 5) begin
            m_prev[a] = m_cur[a];
            m_cur[a]  = host_wdata;
         end else if (core_cnt_we) begin
            m_cur[1] = core_cnt;
         end
         if (clr) begin
            m_stat = 8'h80; m_err = 8'h00;
         end else if (acc) begin
            m_stat = (m_stat | 8'h80) & 8'hFE; m_err = 8'h00;
         end else if (core_upd) begin
            m_stat = core_status & 8'hFD; m_err = core_error & 8'hD5;
         end
         if (clr) m_pend = 0;
         else if (core_irq) m_pend = 1;
         else if (rd && a == 6) m_pend = 0;
         if (wr && a == 7) begin
            m_hob = host_wdata[7]; m_srst = host_wdata[2]; m_nien = host_wdata[1];
         end else if (wr && a <= 6) begin
            m_hob = 0;
         end
         m_cmdv = acc;
         if (acc) m_cmdc = host_wdata;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] exp_rdata();
      int a;
      logic [7:0] v;
      a = int'(host_addr);
      case (a)
         0: return m_err;
         1, 2, 3, 4: return m_hob ? m_prev[a] : m_cur[a];
         5: begin
            v = m_hob ? m_prev[5] : m_cur[5];
            return (v | 8'hA0) & 8'hEF;
         end
         6, 7: return m_stat;
         8: return {1'b0, ~core_wr_active, ~m_cur[5][3:0], 2'b10};
         default: return 8'h00;
      endcase
   endfunction

   always @(negedge clk) begin
      if (chk_on && !done) begin
         chk("R3/R5/R10/R12 host_rdata", 64'(host_rdata), 64'(exp_rdata()));
         chk("R6 cmd_valid", 64'(cmd_valid), 64'(m_cmdv));
         if (m_cmdv) chk("R6 cmd_code", 64'(cmd_code), 64'(m_cmdc));
         chk("R2 feature_out", 64'(feature_out), 64'({m_prev[0], m_cur[0]}));
         chk("R2 count_out", 64'(count_out), 64'({m_prev[1], m_cur[1]}));
         chk("R2 lba_out", 64'(lba_out),
             64'({m_prev[4], m_prev[3], m_prev[2], m_cur[4], m_cur[3], m_cur[2]}));
         chk("R4 head_out", 64'(head_out), 64'(m_cur[5][3:0]));
         chk("R4 lba_mode", 64'(lba_mode), 64'(m_cur[5][6]));
         chk("R11 xfer_sectors", 64'(xfer_sectors),
             64'((m_cur[1] == 8'h00) ? 9'd256 : {1'b0, m_cur[1]}));
         chk("R8 intrq", 64'(intrq), 64'(m_pend && !m_nien));
         chk("R9 soft_rst", 64'(soft_rst), 64'(m_srst));
      end
   end

   task automatic step();
      @(negedge clk); #1;
      host_cs = 0; host_we = 0; core_upd = 0; core_irq = 0; core_cnt_we = 0;
   endtask

   task automatic hw(input logic [3:0] a, input logic [7:0] d);
      step(); host_cs = 1; host_we = 1; host_addr = a; host_wdata = d;
   endtask

   task automatic hr(input logic [3:0] a);
      step(); host_cs = 1; host_we = 0; host_addr = a;
   endtask

   task automatic peek(input logic [3:0] a);
      step(); host_addr = a;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #(20000 * 10);
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      host_addr = 4'd6; #1;
      chk("R1 status reset", 64'(host_rdata), 64'h80);
      host_addr = 4'd0; #1;
      chk("R1 error reset", 64'(host_rdata), 64'h00);
      host_addr = 4'd5; #1;
      chk("R1 devhd reset", 64'(host_rdata), 64'hA0);
      chk("R1 intrq reset", 64'(intrq), 64'h0);
      chk_on = 1'b1;

      // R7 ready stays clear until core update; R6 command blocked while busy
      hw(4'd6, 8'hEC);
      peek(4'd6);
      step(); core_upd = 1; core_status = 8'h52; core_error = 8'hFF;
      peek(4'd0);
      peek(4'd6);

      // R2 double writes, R4 drive/head forced bits
      hw(4'd0, 8'h11); hw(4'd0, 8'h22);
      hw(4'd1, 8'h05); hw(4'd1, 8'h00);
      hw(4'd2, 8'hA1); hw(4'd2, 8'hB1);
      hw(4'd3, 8'hA2); hw(4'd3, 8'hB2);
      hw(4'd4, 8'hA3); hw(4'd4, 8'hB3);
      hw(4'd5, 8'h00); peek(4'd5);
      hw(4'd5, 8'hFF); peek(4'd5); peek(4'd8);
      hw(4'd5, 8'h4A); peek(4'd5);
      // R10 drive address with write in progress
      step(); core_wr_active = 1; host_addr = 4'd8;
      step(); core_wr_active = 0; host_addr = 4'd8;

      // R3 HOB readback then clear by a parameter write
      hw(4'd7, 8'h80);
      for (int a = 1; a <= 5; a++) peek(4'(a));
      hw(4'd2, 8'hC1);
      for (int a = 1; a <= 5; a++) peek(4'(a));
      hw(4'd7, 8'h80); hw(4'd6, 8'h00); peek(4'd3);

      // R6 command accepted after ready (status cleared busy by last core update? re-ready)
      step(); core_upd = 1; core_status = 8'h51; core_error = 8'h04;
      hw(4'd6, 8'h24);
      peek(4'd6); peek(4'd0);
      hw(4'd6, 8'h35);
      peek(4'd6);

      // R11 core count load, same-cycle host write, zero count
      step(); core_cnt_we = 1; core_cnt = 8'h07;
      step(); core_cnt_we = 1; core_cnt = 8'h09; host_cs = 1; host_we = 1;
              host_addr = 4'd1; host_wdata = 8'h33;
      step(); core_cnt_we = 1; core_cnt = 8'h00;
      peek(4'd1);

      // R8 interrupt: aux read keeps, status read clears, set wins, mask
      step(); core_irq = 1;
      hr(4'd7); hr(4'd7);
      hr(4'd6);
      step(); core_irq = 1;
      step(); core_irq = 1; host_cs = 1; host_we = 0; host_addr = 4'd6;
      peek(4'd0);
      hw(4'd7, 8'h02); peek(4'd0);
      hw(4'd7, 8'h00); peek(4'd0);
      hr(4'd6);

      // R9 soft reset held
      step(); core_irq = 1;
      hw(4'd7, 8'h04);
      hw(4'd2, 8'h5A); hw(4'd6, 8'hC8);
      step(); core_upd = 1; core_status = 8'h50; core_error = 8'h00;
      peek(4'd6); peek(4'd2); peek(4'd0);
      hw(4'd7, 8'h00);
      peek(4'd6); hw(4'd6, 8'h90); peek(4'd6);

      // R12 unmapped addresses
      for (int a = 9; a < 16; a++) hr(4'(a));
      step(); step();
      finish_run();
   end

endmodule